// File: doc/BRIEF.md
# Masked Vector Arithmetic Sequencer

The block runs one vector arithmetic instruction at a time over a bank of vector registers. Each register holds up to 64 elements of 64 bits. A start pulse hands over an opcode, two source register numbers, a destination number, a scalar operand, a mask-enable bit and a vector length. The block then feeds one element per clock into an integer functional unit whose startup delay depends on the operation. Results come back in ascending element order, one per clock, and are written back to the destination. A single-cycle done pulse closes the instruction.

The operations are add, subtract and multiply, each in a vector-vector form and a vector-scalar form, plus a not-equal compare. The compare writes a per-element mask instead of a register. Later arithmetic instructions with the mask-enable bit set write only the elements whose mask bit is 1. An element load port and a combinational element read port give access to the register bank while the block is idle. A writeback stream shows each result in the cycle before it is committed.

Top module: `vseq_top`

## Requirements
- R1: After reset, `done` and `wb_valid` are 0 and every bit of `mask_bits` is 0.
- R2: `opcode[1:0]` selects the operation: 0 add, 1 subtract, 2 multiply, 3 not-equal compare. Add, subtract and multiply results are the low 64 bits of the exact integer result of source A op source B. The destination may be the same register as a source.
- R3: With `opcode[2]` = 1 (scalar form), the `scalar` input replaces the source B element for every element. With `opcode[2]` = 0, element i of source B is used.
- R4: The first result is committed 6 clock edges after the edge that accepts start for add, subtract and compare, and 7 edges after it for multiply. Element i is committed i edges after element 0, and `wb_valid` is high with `wb_idx` = i in the cycle before that edge.
- R5: Only elements 0 to VL-1 are processed, with VL taken from `vlen` at start. A `vlen` of 0 or above 64 means 64. Elements at index VL and above keep their contents.
- R6: A compare sets mask bit i to 1 when source A element i differs from the second operand and clears it when they are equal, for i below VL. Mask bits at VL and above keep their value. No register element changes, and `mask_en` has no effect on a compare.
- R7: With `mask_en` = 1, add, subtract and multiply write only the elements whose current mask bit is 1. The other destination elements keep their contents, and `wb_we` is 0 for them.
- R8: With `mask_en` = 0, every element below VL is written, whatever the mask holds.
- R9: `done` is high for exactly one cycle: the cycle that follows the edge at which the last element (index VL-1) is committed.
- R10: A start pulse that arrives while an instruction is running is ignored. The running instruction is not disturbed and no extra results appear.
- R11: While idle, a load with `ld_en` = 1 writes `ld_data` into element `ld_idx` of register `ld_reg` at the next edge. A load attempted while an instruction runs is ignored. `rd_data` shows element `rd_idx` of register `rd_reg` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction start pulse |
| opcode | input | 3 | Bit 2 scalar form, bits 1:0 operation |
| src_a | input | 3 | Source A register number |
| src_b | input | 3 | Source B register number |
| dst | input | 3 | Destination register number |
| scalar | input | 64 | Scalar operand |
| mask_en | input | 1 | Gate arithmetic writeback by the mask |
| vlen | input | 7 | Vector length for this instruction |
| done | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Element load strobe |
| ld_reg | input | 3 | Load register number |
| ld_idx | input | 6 | Load element index |
| ld_data | input | 64 | Load data |
| rd_reg | input | 3 | Read register number |
| rd_idx | input | 6 | Read element index |
| rd_data | output | 64 | Read data |
| mask_bits | output | 64 | Current mask, bit i for element i |
| wb_valid | output | 1 | A result is committed at the next edge |
| wb_idx | output | 6 | Element index of that result |
| wb_data | output | 64 | Result value; bit 0 is the compare outcome |
| wb_we | output | 1 | Result is written (mask permits) |

## Verification
The hardest situation to reach is a start or load that collides with an instruction in flight. The bench can only provoke it by driving those pins in a cycle it knows lies strictly between accept and done. It therefore times a second start and an element load two cycles into a 16-element add. The scoreboard then shows that no stray results appear, and later read-back of the untouched register and the mask shows that nothing changed. A second hard case is the mask persisting across instructions. It is reached by running a full-length compare, then a short compare that leaves the upper mask bits alone, then a masked add whose write pattern depends on both.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        VOP_ADD = 2'd0,
        VOP_SUB = 2'd1,
        VOP_MUL = 2'd2,
        VOP_CNE = 2'd3
    } vop_e;

    // Startup delay in clocks for an operation kind
    function automatic int unsigned op_latency(vop_e kind,
                                               int unsigned lat_add,
                                               int unsigned lat_mul);
        return (kind == VOP_MUL) ? lat_mul : lat_add;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vseq_alu.sv
module vseq_alu
    import vseq_pkg::*;
#(
    parameter int W = 64
) (
    input  vop_e           kind,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [W-1:0]   res
);
    always_comb begin
        unique case (kind)
            VOP_ADD: res = opa + opb;
            VOP_SUB: res = opa - opb;
            VOP_MUL: res = opa * opb;
            default: res = W'(opa != opb);
        endcase
    end
endmodule

// File: rtl/vseq_regfile.sv
module vseq_regfile #(
    parameter int W     = 64,
    parameter int NREG  = 8,
    parameter int DEPTH = 64,
    parameter int NRD   = 3,
    localparam int RW   = $clog2(NREG),
    localparam int IW   = $clog2(DEPTH),
    localparam int AW   = $clog2(NREG * DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [RW-1:0]   wreg,
    input  logic [IW-1:0]   widx,
    input  logic [W-1:0]    wdata,
    input  logic [RW-1:0]   rreg  [NRD],
    input  logic [IW-1:0]   ridx  [NRD],
    output logic [W-1:0]    rdata [NRD]
);
    logic [W-1:0] mem [NREG * DEPTH];

    function automatic logic [AW-1:0] flat(logic [RW-1:0] r, logic [IW-1:0] i);
        return AW'(int'(r) * DEPTH + int'(i));
    endfunction

    always_ff @(posedge clk) begin
        if (we) mem[flat(wreg, widx)] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[flat(rreg[p], ridx[p])];
    end
endmodule

// File: rtl/vseq_delay.sv
module vseq_delay #(
    parameter int  DEPTH = 6,
    parameter type item_t = logic,
    localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  item_t         din,
    input  logic [TW-1:0] tap,
    output item_t         dout
);
    item_t stg [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         stg[k] <= '0;
            else if (k == 0) stg[k] <= din;
            else             stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[tap];

    // R4
    tap_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(tap) < DEPTH);
endmodule

// File: rtl/vseq_top.sv
module vseq_top
    import vseq_pkg::*;
#(
    parameter int W       = 64,
    parameter int NREG    = 8,
    parameter int MAX_VL  = 64,
    parameter int LAT_ADD = 6,
    parameter int LAT_MUL = 7,
    localparam int RW     = $clog2(NREG),
    localparam int IW     = $clog2(MAX_VL),
    localparam int VLW    = $clog2(MAX_VL + 1),
    localparam int MAXLAT = max_u(LAT_ADD, LAT_MUL),
    localparam int DEPTH  = MAXLAT - 1,
    localparam int TW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SW     = $clog2(MAXLAT + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        opcode,
    input  logic [RW-1:0]     src_a,
    input  logic [RW-1:0]     src_b,
    input  logic [RW-1:0]     dst,
    input  logic [W-1:0]      scalar,
    input  logic              mask_en,
    input  logic [VLW-1:0]    vlen,
    output logic              done,
    input  logic              ld_en,
    input  logic [RW-1:0]     ld_reg,
    input  logic [IW-1:0]     ld_idx,
    input  logic [W-1:0]      ld_data,
    input  logic [RW-1:0]     rd_reg,
    input  logic [IW-1:0]     rd_idx,
    output logic [W-1:0]      rd_data,
    output logic [MAX_VL-1:0] mask_bits,
    output logic              wb_valid,
    output logic [IW-1:0]     wb_idx,
    output logic [W-1:0]      wb_data,
    output logic              wb_we
);
    typedef struct packed {
        logic          vld;
        logic          cmp;
        logic          wen;
        logic [IW-1:0] idx;
        logic [W-1:0]  data;
    } wb_item_t;

    typedef struct packed {
        vop_e          kind;
        logic          use_scalar;
        logic          gate;
        logic [RW-1:0] sa;
        logic [RW-1:0] sb;
        logic [RW-1:0] sd;
        logic [W-1:0]  sval;
        logic [TW-1:0] tap;
    } instr_t;

    // ---------------- control state ----------------
    logic              busy_q;
    logic [VLW-1:0]    issue_q;
    logic [VLW-1:0]    vl_q;
    instr_t            ins_q;
    logic              done_q;
    logic [MAX_VL-1:0] mask_q;

    logic              accept;
    logic [VLW-1:0]    vl_in;
    logic              issuing;
    logic [IW-1:0]     iss_idx;
    logic              last_wb;
    vop_e              kind_in;

    assign accept  = start && !busy_q;
    assign kind_in = vop_e'(opcode[1:0]);
    assign vl_in   = (vlen == '0 || vlen > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vlen;
    assign issuing = busy_q && (issue_q < vl_q);
    assign iss_idx = issue_q[IW-1:0];

    // ---------------- register bank ----------------
    logic [RW-1:0] rf_rreg  [3];
    logic [IW-1:0] rf_ridx  [3];
    logic [W-1:0]  rf_rdata [3];
    logic          rf_we;
    logic [RW-1:0] rf_wreg;
    logic [IW-1:0] rf_widx;
    logic [W-1:0]  rf_wdata;
    wb_item_t      wbi;
    logic          wb_commit;

    assign rf_rreg[0] = ins_q.sa;  assign rf_ridx[0] = iss_idx;
    assign rf_rreg[1] = ins_q.sb;  assign rf_ridx[1] = iss_idx;
    assign rf_rreg[2] = rd_reg;    assign rf_ridx[2] = rd_idx;

    assign wb_commit = wbi.vld && !wbi.cmp && wbi.wen;
    assign rf_we     = wb_commit || (ld_en && !busy_q);
    assign rf_wreg   = wb_commit ? ins_q.sd : ld_reg;
    assign rf_widx   = wb_commit ? wbi.idx  : ld_idx;
    assign rf_wdata  = wb_commit ? wbi.data : ld_data;

    vseq_regfile #(.W(W), .NREG(NREG), .DEPTH(MAX_VL), .NRD(3)) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .wreg  (rf_wreg),
        .widx  (rf_widx),
        .wdata (rf_wdata),
        .rreg  (rf_rreg),
        .ridx  (rf_ridx),
        .rdata (rf_rdata)
    );

    // ---------------- functional unit ----------------
    logic [W-1:0] opb;
    logic [W-1:0] alu_res;
    wb_item_t     iss_item;

    assign opb = ins_q.use_scalar ? ins_q.sval : rf_rdata[1];

    vseq_alu #(.W(W)) u_alu (
        .kind (ins_q.kind),
        .opa  (rf_rdata[0]),
        .opb  (opb),
        .res  (alu_res)
    );

    always_comb begin
        iss_item.vld  = issuing;
        iss_item.cmp  = (ins_q.kind == VOP_CNE);
        iss_item.wen  = iss_item.cmp || !ins_q.gate || mask_q[iss_idx];
        iss_item.idx  = iss_idx;
        iss_item.data = alu_res;
    end

    vseq_delay #(.DEPTH(DEPTH), .item_t(wb_item_t)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (iss_item),
        .tap  (ins_q.tap),
        .dout (wbi)
    );

    assign last_wb = wbi.vld && ({1'b0, wbi.idx} == vl_q - VLW'(1));

    // ---------------- sequencing ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            issue_q <= '0;
            vl_q    <= VLW'(1);
            ins_q   <= '0;
            done_q  <= 1'b0;
            mask_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q           <= 1'b1;
                issue_q          <= '0;
                vl_q             <= vl_in;
                ins_q.kind       <= kind_in;
                ins_q.use_scalar <= opcode[2];
                ins_q.gate       <= mask_en;
                ins_q.sa         <= src_a;
                ins_q.sb         <= src_b;
                ins_q.sd         <= dst;
                ins_q.sval       <= scalar;
                ins_q.tap        <= TW'(op_latency(kind_in, LAT_ADD, LAT_MUL) - 2);
            end else if (busy_q) begin
                if (issuing) issue_q <= issue_q + VLW'(1);
                if (last_wb) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
            if (wbi.vld && wbi.cmp) mask_q[wbi.idx] <= wbi.data[0];
        end
    end

    assign done      = done_q;
    assign rd_data   = rf_rdata[2];
    assign mask_bits = mask_q;
    assign wb_valid  = wbi.vld;
    assign wb_idx    = wbi.idx;
    assign wb_data   = wbi.data;
    assign wb_we     = wbi.wen;

    // ---------------- checks ----------------
    logic [SW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (rst)                           since_q <= '0;
        else if (accept)                   since_q <= SW'(1);
        else if (since_q < SW'(MAXLAT + 1)) since_q <= since_q + SW'(1);
    end

    // R4
    first_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_idx == '0) |-> (int'(since_q) == int'(ins_q.tap) + 2));

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && $past(wb_valid)) |-> (wb_idx == IW'($past(wb_idx) + 1'b1)));

    // R5
    wb_range_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> ({1'b0, wb_idx} < vl_q));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wb_valid) && ({1'b0, $past(wb_idx)} == vl_q - VLW'(1))));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && busy_q) |=> ($stable(vl_q) && $stable(ins_q)));
endmodule

// File: tb/vseq_top_tb.sv
module vseq_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  opcode = '0;
    logic [2:0]  src_a = '0, src_b = '0, dst = '0;
    logic [63:0] scalar = '0;
    logic        mask_en = 1'b0;
    logic [6:0]  vlen = 7'd1;
    logic        done;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_reg = '0;
    logic [5:0]  ld_idx = '0;
    logic [63:0] ld_data = '0;
    logic [2:0]  rd_reg = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic [63:0] mask_bits;
    logic        wb_valid;
    logic [5:0]  wb_idx;
    logic [63:0] wb_data;
    logic        wb_we;

    always #10 clk = ~clk;

    vseq_top u_dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .dst(dst), .scalar(scalar),
        .mask_en(mask_en), .vlen(vlen), .done(done),
        .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
        .mask_bits(mask_bits), .wb_valid(wb_valid), .wb_idx(wb_idx),
        .wb_data(wb_data), .wb_we(wb_we)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [63:0] m_rf [8][64];
    logic [63:0] m_mask = '0;

    typedef struct {
        int          idx;
        logic [63:0] data;
        bit          we;
        int          at;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected result per writeback cycle
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (wb_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected writeback idx", 64'(wb_idx), 64'hFFFF);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(int'(wb_idx) == e.idx, "R4", "writeback order", 64'(wb_idx), 64'(e.idx));
                    chk(cyc == e.at, "R4", "writeback cycle", 64'(cyc), 64'(e.at));
                    chk(wb_data == e.data, e.req, "writeback data", wb_data, e.data);
                    chk(wb_we == e.we, "R7/R8", "writeback enable", 64'(wb_we), 64'(e.we));
                end
            end
        end
    end

    task automatic load(input int r, input int i, input logic [63:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_reg = 3'(r); ld_idx = 6'(i); ld_data = v;
        m_rf[r][i] = v;
    endtask

    task automatic check_reg(input int r, input string req);
        int bad = 0;
        logic [63:0] a0 = '0, e0 = '0;
        for (int i = 0; i < 64; i++) begin
            rd_reg = 3'(r); rd_idx = 6'(i);
            #1;
            if (rd_data !== m_rf[r][i]) begin
                if (bad == 0) begin a0 = rd_data; e0 = m_rf[r][i]; end
                bad++;
            end
        end
        chk(bad == 0, req, $sformatf("register %0d contents", r), a0, e0);
    endtask

    task automatic run_op(input logic [2:0] op, input int a, input int b, input int d,
                          input logic [63:0] sc, input bit men, input int vreq,
                          input bit inject, input string req);
        int vl  = (vreq == 0 || vreq > 64) ? 64 : vreq;
        int lat = (op[1:0] == 2'd2) ? 7 : 6;
        int c0;
        logic [63:0] newm = m_mask;
        @(negedge clk);
        ld_en = 1'b0;
        start = 1'b1; opcode = op; src_a = 3'(a); src_b = 3'(b); dst = 3'(d);
        scalar = sc; mask_en = men; vlen = 7'(vreq);
        c0 = cyc;
        for (int i = 0; i < vl; i++) begin
            logic [63:0] x = m_rf[a][i];
            logic [63:0] y = op[2] ? sc : m_rf[b][i];
            logic [63:0] r;
            exp_t e;
            bit we;
            case (op[1:0])
                2'd0: r = x + y;
                2'd1: r = x - y;
                2'd2: r = x * y;
                default: r = {63'b0, x != y};
            endcase
            if (op[1:0] == 2'd3) begin
                we = 1'b1;
                newm[i] = (x != y);
            end else begin
                we = !men || m_mask[i];
                if (we) m_rf[d][i] = r;
            end
            e.idx = i; e.data = r; e.we = we; e.at = c0 + lat + i; e.req = req;
            sb_q.push_back(e);
        end
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            @(negedge clk);
            start = 1'b1; opcode = 3'b111; scalar = '0; vlen = 7'd64; dst = 3'd7;
            ld_en = 1'b1; ld_reg = 3'd7; ld_idx = 6'd5; ld_data = 64'hDEAD_BEEF_0BAD_F00D;
            @(negedge clk);
            start = 1'b0; ld_en = 1'b0;
        end
        while (cyc < c0 + lat + vl - 1) @(negedge clk);
        chk(done == 1'b0, "R9", "done before last commit", 64'(done), 64'd0);
        @(negedge clk);
        chk(done == 1'b1, "R9", "done after last commit", 64'(done), 64'd1);
        m_mask = newm;
        @(negedge clk);
        chk(done == 1'b0, "R9", "done width", 64'(done), 64'd0);
        chk(sb_q.size() == 0, req, "results outstanding", 64'(sb_q.size()), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
        chk(wb_valid == 1'b0, "R1", "wb_valid after reset", 64'(wb_valid), 64'd0);
        chk(mask_bits == '0, "R1", "mask after reset", mask_bits, 64'd0);

        // R11: fill every register through the load port
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 64; i++) begin
                logic [63:0] v = 64'h9E37_79B9_7F4A_7C15 * 64'(r * 64 + i + 1);
                if (r == 1) v = 64'hFFFF_FFFF_FFFF_FFF0 + 64'(i);
                if (r == 2) v = (i % 3 == 0) ? m_rf[0][i] : m_rf[0][i] + 64'd1;
                if (r == 3) v = 64'(i * 7);
                load(r, i, v);
            end
        @(negedge clk);
        ld_en = 1'b0;
        check_reg(0, "R11");
        check_reg(2, "R11");

        // R2 R8: vector-vector add, full length, carries wrap
        run_op(3'b000, 0, 1, 4, '0, 1'b0, 64, 1'b0, "R2");
        check_reg(4, "R2");
        // R5: short subtract leaves upper elements
        run_op(3'b001, 0, 1, 5, '0, 1'b0, 10, 1'b0, "R5");
        check_reg(5, "R5");
        // R4: multiply uses the longer startup
        run_op(3'b010, 1, 3, 6, '0, 1'b0, 64, 1'b0, "R2");
        check_reg(6, "R2");
        // R3: scalar multiply
        run_op(3'b110, 3, 0, 7, 64'h0000_0001_0000_0003, 1'b0, 33, 1'b0, "R3");
        check_reg(7, "R3");
        // R6: compare against scalar zero, element 0 of r3 equals it
        run_op(3'b111, 3, 0, 4, 64'd0, 1'b1, 64, 1'b0, "R6");
        chk(mask_bits == m_mask, "R6", "mask after scalar compare", mask_bits, m_mask);
        chk(mask_bits == 64'hFFFF_FFFF_FFFF_FFFE, "R6", "mask value", mask_bits,
            64'hFFFF_FFFF_FFFF_FFFE);
        check_reg(4, "R6");
        // R6: short vector compare keeps mask bits 20 and up
        run_op(3'b011, 0, 2, 4, '0, 1'b0, 20, 1'b0, "R6");
        chk(mask_bits == m_mask, "R6", "mask after short compare", mask_bits, m_mask);
        // R7: masked scalar add
        run_op(3'b100, 0, 0, 5, 64'd1000, 1'b1, 40, 1'b0, "R7");
        check_reg(5, "R7");
        // R8 R5: unmasked subtract with vlen 0 meaning full length
        run_op(3'b001, 2, 0, 6, '0, 1'b0, 0, 1'b0, "R8");
        check_reg(6, "R8");
        // R5: vlen above the maximum clamps to full length
        run_op(3'b100, 3, 0, 7, 64'd5, 1'b0, 100, 1'b0, "R5");
        check_reg(7, "R5");
        // R9: single element
        run_op(3'b010, 0, 1, 4, '0, 1'b0, 1, 1'b0, "R9");
        check_reg(4, "R9");
        // R10 R11: start and load while busy are dropped
        run_op(3'b000, 3, 1, 4, '0, 1'b0, 16, 1'b1, "R10");
        repeat (10) @(negedge clk);
        check_reg(4, "R10");
        check_reg(7, "R11");
        chk(mask_bits == m_mask, "R10", "mask untouched by dropped start", mask_bits, m_mask);
        // R2: destination equals source
        run_op(3'b100, 3, 0, 3, 64'd1, 1'b0, 64, 1'b0, "R2");
        check_reg(3, "R2");

        repeat (10) @(negedge clk);
        chk(sb_q.size() == 0, "R10", "no stray results", 64'(sb_q.size()), 64'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule